// File: doc/BRIEF.md
# Monochrome Graphic Panel Host Port

This block is the processor-facing port of a monochrome dot-matrix panel controller for a 64-line by 128-column panel. A host talks to it over an 8-bit parallel bus with a strobe (E), a register/data select (RS), a read/write select (RW) and two active-low selects, one per 64-column half. Each half has its own page, column and start-line registers, its own on/off flag, its own busy timer and its own read buffer. Each half also has a byte-wide pixel store of 8 pages by 64 columns. A stored 1 is a lit pixel. Bit 0 of a byte is the top line of its page.

Bus events are taken on the falling edge of E, after the strobe and its companions pass through a two-stage synchroniser into the system clock. A data read hands the host the current contents of the read buffer, then refills the buffer from the store. The first read after an address change is therefore a dummy. A direction pin, when low, mirrors the physical column order and exchanges the two selects. A scan-side port gives read-only access by page and physical column for the display engine.

Each half runs a three-state machine:
- ST_RESET holds the registers while the reset input is low.
- ST_RESET goes to ST_READY on the first clock after reset is released.
- ST_READY goes to ST_BUSY on any accepted write, whether data or command.
- ST_BUSY goes back to ST_READY when its down-counter expires, BUSY_CYC clocks later.
- Reset low forces ST_RESET from any state.

Top module: `glcd_host_if`

## Requirements
- R1: While rst_n is low, data writes, data reads and commands are ignored and leave the store unchanged, and only status reads answer. Status during reset reads 0x30. Reset leaves each half off, with page, column and start line at 0 and the read buffer at 0x00.
- R2: The status byte is {busy, 0, off, in_reset, 0000}. Bit 7 is busy, bit 5 is 1 when the half is off, and bit 4 is 1 during reset.
- R3: With RS=0 and RW=0, the byte 0011111D turns the half on (D=1) or off (D=0), as seen on disp_on_o[h] and status bit 5.
- R4: With RS=0 and RW=0, the byte 10111PPP loads the page, 01CCCCCC loads the column, and 11LLLLLL loads the start line, which appears on start_line_o[6h+5:6h].
- R5: A write with RS=1 and RW=0 stores the byte at the current page and column, then advances the column by one. The column wraps from 63 to 0.
- R6: A read with RS=1 and RW=1 returns the read buffer, refills the buffer from the current address, and advances the column by one. The first read after an address change returns stale data.
- R7: After each accepted write or command, a half reports busy for BUSY_CYC clocks. Any access other than a status read arriving while busy is dropped and does not move the column.
- R8: bus_cs_a_n low selects the half showing physical columns 0..63 and bus_cs_b_n low selects the half showing 64..127, each half independent of the other. With both selects high, nothing is driven and writes are ignored.
- R9: bus_oe is high only while E is high, RW is 1 and at least one select is low.
- R10: With dir_norm low, bus_cs_a_n addresses the second half and bus_cs_b_n the first. Logical column c of half h appears at physical column 127 − (64h + c).
- R11: Loading page or column changes neither the scan data nor the on/off state.
- R12: An access takes effect only after the falling edge of E. Nothing changes while E stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the controller |
| bus_e | input | 1 | Host strobe; accesses act on its falling edge |
| bus_rs | input | 1 | 1 = display data, 0 = command/status |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_cs_a_n | input | 1 | Active-low select of the first half |
| bus_cs_b_n | input | 1 | Active-low select of the second half |
| dir_norm | input | 1 | 1 = normal column order, 0 = mirrored with selects swapped |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Host read data |
| bus_oe | output | 1 | Output enable for bus_dout |
| disp_on_o | output | 2 | On flag per half |
| start_line_o | output | 12 | Start line per half, 6 bits each |
| scan_page_i | input | 3 | Scan-side page |
| scan_col_i | input | 7 | Scan-side physical column |
| scan_data_o | output | 8 | Byte at scan page and column |

## Verification
The bench targets the dummy-read pipeline. A design that reads the store directly would return the addressed byte one read early. It also checks that a write arriving during busy is dropped and does not advance the column; a design that skips the drop would place the next byte one column late. Further cases are the 63-to-0 column wrap, mirrored mode (a wrong mapping lands the byte at column 64 instead of 63, or answers status for the wrong half), writes with both selects high, writes during reset, and a strobe held high, which a level-triggered design would act on too early.

// File: rtl/glcd_pkg.sv
package glcd_pkg;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 3;
    localparam int COL_W  = 6;
    localparam int LINE_W = 6;
    localparam int NHALF  = 2;
    localparam int PCOL_W = COL_W + 1;

    typedef struct packed {
        logic              e;
        logic              rs;
        logic              rw;
        logic              cs_a_n;
        logic              cs_b_n;
        logic [DATA_W-1:0] d;
    } pins_t;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_READY = 2'd1,
        ST_BUSY  = 2'd2
    } half_state_t;
endpackage

// File: rtl/glcd_bus_sync.sv
module glcd_bus_sync
    import glcd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  pins_t             pins_i,
    output logic              fall_o,
    output logic              rs_o,
    output logic              rw_o,
    output logic              cs_a_n_o,
    output logic              cs_b_n_o,
    output logic [DATA_W-1:0] d_o
);
    pins_t pipe [STAGES+1];

    always_ff @(posedge clk) begin
        pipe[0] <= pins_i;
        for (int i = 1; i <= STAGES; i++) begin
            pipe[i] <= pipe[i-1];
        end
    end

    // falling strobe: oldest stage still high, next one already low
    assign fall_o   = pipe[STAGES].e & ~pipe[STAGES-1].e;
    assign rs_o     = pipe[STAGES].rs;
    assign rw_o     = pipe[STAGES].rw;
    assign cs_a_n_o = pipe[STAGES].cs_a_n;
    assign cs_b_n_o = pipe[STAGES].cs_b_n;
    assign d_o      = pipe[STAGES].d;
endmodule

// File: rtl/glcd_half.sv
module glcd_half
    import glcd_pkg::*;
#(
    parameter int BUSY_CYC = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              rs_i,
    input  logic              rw_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              rd_rs_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [PAGE_W-1:0] scan_page_i,
    input  logic [COL_W-1:0]  scan_col_i,
    output logic [DATA_W-1:0] scan_data_o,
    output logic              disp_on_o,
    output logic [LINE_W-1:0] start_line_o
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam int DEPTH = (1 << PAGE_W) * (1 << COL_W);

    half_state_t state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  col;
    logic [LINE_W-1:0] line;
    logic              on;
    logic [DATA_W-1:0] rbuf;
    logic [DATA_W-1:0] mem [DEPTH];

    logic wr_acc, take, busy, in_reset;
    assign wr_acc   = evt_i & ~rw_i;
    assign take     = (state == ST_READY) & evt_i;
    assign busy     = (state == ST_BUSY);
    assign in_reset = (state == ST_RESET);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RESET: state_nx = ST_READY;
            ST_READY: if (wr_acc) state_nx = ST_BUSY;
            ST_BUSY:  if (cnt == CNT_W'(1)) state_nx = ST_READY;
            default:  state_nx = ST_RESET;
        endcase
    end

    // state register and busy timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RESET;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (take && wr_acc)
                cnt <= CNT_W'(BUSY_CYC);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // registers driven by accepted accesses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= '0;
            col  <= '0;
            line <= '0;
            on   <= 1'b0;
            rbuf <= '0;
        end else if (take) begin
            if (!rs_i && !rw_i) begin
                if (din_i[7:1] == 7'b0011111)
                    on <= din_i[0];
                else if (din_i[7:6] == 2'b11)
                    line <= din_i[LINE_W-1:0];
                else if (din_i[7:3] == 5'b10111)
                    page <= din_i[PAGE_W-1:0];
                else if (din_i[7:6] == 2'b01)
                    col <= din_i[COL_W-1:0];
            end else if (rs_i) begin
                col <= col + 1'b1;
            end
            if (rs_i && rw_i)
                rbuf <= mem[{page, col}];
        end
    end

    always_ff @(posedge clk) begin
        if (take && rs_i && !rw_i)
            mem[{page, col}] <= din_i;
    end

    assign rd_data_o    = rd_rs_i ? rbuf : {busy, 1'b0, ~on, in_reset, 4'b0000};
    assign scan_data_o  = mem[{scan_page_i, scan_col_i}];
    assign disp_on_o    = on;
    assign start_line_o = line;

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && evt_i && !rw_i) |=> busy); // R7
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && evt_i) |=> ($stable(col) && $stable(page) && $stable(on)
                             && $stable(line) && $stable(rbuf))); // R7
    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && evt_i && rs_i) |=> (col == $past(col) + 1'b1)); // R5
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(state == ST_READY && evt_i && rs_i && rw_i) |-> $stable(rbuf)); // R6
endmodule

// File: rtl/glcd_host_if.sv
module glcd_host_if
    import glcd_pkg::*;
#(
    parameter int BUSY_CYC = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_e,
    input  logic                    bus_rs,
    input  logic                    bus_rw,
    input  logic                    bus_cs_a_n,
    input  logic                    bus_cs_b_n,
    input  logic                    dir_norm,
    input  logic [7:0]              bus_din,
    output logic [7:0]              bus_dout,
    output logic                    bus_oe,
    output logic [1:0]              disp_on_o,
    output logic [11:0]             start_line_o,
    input  logic [2:0]              scan_page_i,
    input  logic [6:0]              scan_col_i,
    output logic [7:0]              scan_data_o
);
    pins_t raw;
    logic              evt, c_rs, c_rw, c_a_n, c_b_n;
    logic [DATA_W-1:0] c_d;
    logic [NHALF-1:0]  sel_cap, sel_raw;
    logic [PCOL_W-1:0] lcol;
    logic [DATA_W-1:0] rd_data   [NHALF];
    logic [DATA_W-1:0] scan_half [NHALF];

    assign raw = {bus_e, bus_rs, bus_rw, bus_cs_a_n, bus_cs_b_n, bus_din};

    glcd_bus_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .pins_i   (raw),
        .fall_o   (evt),
        .rs_o     (c_rs),
        .rw_o     (c_rw),
        .cs_a_n_o (c_a_n),
        .cs_b_n_o (c_b_n),
        .d_o      (c_d)
    );

    // select routing; mirrored mode exchanges the two selects
    assign sel_cap = dir_norm ? {~c_b_n, ~c_a_n} : {~c_a_n, ~c_b_n};
    assign sel_raw = dir_norm ? {~bus_cs_b_n, ~bus_cs_a_n} : {~bus_cs_a_n, ~bus_cs_b_n};

    // physical to logical column: mirror is 127 - p
    assign lcol = dir_norm ? scan_col_i : ~scan_col_i;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        glcd_half #(.BUSY_CYC(BUSY_CYC)) u_half (
            .clk          (clk),
            .rst_n        (rst_n),
            .evt_i        (evt & sel_cap[h]),
            .rs_i         (c_rs),
            .rw_i         (c_rw),
            .din_i        (c_d),
            .rd_rs_i      (bus_rs),
            .rd_data_o    (rd_data[h]),
            .scan_page_i  (scan_page_i),
            .scan_col_i   (lcol[COL_W-1:0]),
            .scan_data_o  (scan_half[h]),
            .disp_on_o    (disp_on_o[h]),
            .start_line_o (start_line_o[h*LINE_W +: LINE_W])
        );
    end

    assign bus_dout    = sel_raw[0] ? rd_data[0] : rd_data[1];
    assign bus_oe      = bus_e & bus_rw & (|sel_raw);
    assign scan_data_o = scan_half[lcol[PCOL_W-1]];

    always_comb begin
        if (bus_cs_a_n && bus_cs_b_n)
            AST_QUIET_BUS: assert (!bus_oe); // R8
    end
endmodule

// File: tb/glcd_host_if_tb_top.sv
module glcd_host_if_tb_top;
    localparam int BUSY_CYC = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_e = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
    logic        bus_cs_a_n = 1'b1, bus_cs_b_n = 1'b1, dir_norm = 1'b1;
    logic [7:0]  bus_din = 8'h00;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic [1:0]  disp_on_o;
    logic [11:0] start_line_o;
    logic [2:0]  scan_page_i = 3'd0;
    logic [6:0]  scan_col_i = 7'd0;
    logic [7:0]  scan_data_o;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    event       smp_ev;

    always #2 clk = ~clk;

    glcd_host_if #(.BUSY_CYC(BUSY_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rs(bus_rs), .bus_rw(bus_rw),
        .bus_cs_a_n(bus_cs_a_n), .bus_cs_b_n(bus_cs_b_n), .dir_norm(dir_norm),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .disp_on_o(disp_on_o), .start_line_o(start_line_o),
        .scan_page_i(scan_page_i), .scan_col_i(scan_col_i), .scan_data_o(scan_data_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic a_n, input logic b_n, input logic rs,
                         input logic rw, input logic [7:0] d);
        @(negedge clk);
        bus_cs_a_n = a_n; bus_cs_b_n = b_n; bus_rs = rs; bus_rw = rw; bus_din = d;
        @(negedge clk);
        bus_e = 1'b1;
    endtask

    task automatic wr(input logic a_n, input logic b_n, input logic rs, input logic [7:0] d);
        drive(a_n, b_n, rs, 1'b0, d);
        repeat (4) @(negedge clk);
        bus_e = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_w(input logic a_n, input logic b_n, input logic rs, input logic [7:0] d);
        wr(a_n, b_n, rs, d);
        repeat (BUSY_CYC + 16) @(negedge clk);
    endtask

    // driver: queue the expected byte, then strobe a read
    task automatic rd(input logic a_n, input logic b_n, input logic rs,
                      input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        drive(a_n, b_n, rs, 1'b1, 8'h00);
        repeat (3) @(negedge clk);
        -> smp_ev;
        @(negedge clk);
        bus_e = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic scan(input int page, input int pcol, input int exp, input string tag);
        @(negedge clk);
        scan_page_i = 3'(page);
        scan_col_i  = 7'(pcol);
        @(negedge clk);
        chk(tag, int'(scan_data_o), exp);
    endtask

    // monitor: pop and compare as each read is presented
    initial begin
        forever begin
            @(smp_ev);
            chk({tag_q[0], " oe"}, int'(bus_oe), 1);
            chk(tag_q[0], int'(bus_dout), int'(exp_q[0]));
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R12 actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rd(1'b0, 1'b1, 1'b0, 8'h30, "R1 status in reset A");
        rd(1'b1, 1'b0, 1'b0, 8'h30, "R2 status in reset B");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        rd(1'b0, 1'b1, 1'b0, 8'h20, "R2 status after reset");
        chk("R1 off after reset", int'(disp_on_o), 0);

        wr_w(1'b0, 1'b0, 1'b0, 8'h3F);
        chk("R3 both on", int'(disp_on_o), 3);
        rd(1'b0, 1'b1, 1'b0, 8'h00, "R3 status on");

        wr_w(1'b0, 1'b1, 1'b0, 8'hBA);
        wr_w(1'b0, 1'b1, 1'b0, 8'h45);
        wr_w(1'b0, 1'b1, 1'b1, 8'hA5);
        wr_w(1'b0, 1'b1, 1'b1, 8'h3C);
        scan(2, 5, 8'hA5, "R5 write col5");
        scan(2, 6, 8'h3C, "R5 write col6");

        wr_w(1'b0, 1'b1, 1'b0, 8'h45);
        rd(1'b0, 1'b1, 1'b1, 8'h00, "R6 dummy read");
        rd(1'b0, 1'b1, 1'b1, 8'hA5, "R6 first real read");
        rd(1'b0, 1'b1, 1'b1, 8'h3C, "R6 read advances column");

        wr_w(1'b0, 1'b1, 1'b0, 8'hB8);
        wr_w(1'b0, 1'b1, 1'b0, 8'h40);
        scan(2, 5, 8'hA5, "R11 scan unchanged by address");
        chk("R11 on state unchanged", int'(disp_on_o), 3);

        wr_w(1'b0, 1'b1, 1'b0, 8'h4A);
        wr(1'b0, 1'b1, 1'b1, 8'h11);
        rd(1'b0, 1'b1, 1'b0, 8'h80, "R7 busy status");
        wr(1'b0, 1'b1, 1'b1, 8'h22);
        repeat (BUSY_CYC + 16) @(negedge clk);
        rd(1'b0, 1'b1, 1'b0, 8'h00, "R7 busy cleared");
        wr_w(1'b0, 1'b1, 1'b1, 8'h33);
        scan(0, 10, 8'h11, "R7 dropped write kept col10");
        scan(0, 11, 8'h33, "R7 dropped write no column step");

        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        repeat (3) @(negedge clk);
        chk("R8 no drive when unselected", int'(bus_oe), 0);
        bus_e = 1'b0;
        repeat (4) @(negedge clk);
        wr_w(1'b1, 1'b1, 1'b1, 8'h77);
        wr_w(1'b0, 1'b1, 1'b1, 8'h44);
        scan(0, 12, 8'h44, "R8 unselected write ignored");

        drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
        bus_e = 1'b0;
        @(negedge clk);
        chk("R9 no drive with E low", int'(bus_oe), 0);

        wr_w(1'b1, 1'b0, 1'b0, 8'hBA);
        wr_w(1'b1, 1'b0, 1'b0, 8'h45);
        wr_w(1'b1, 1'b0, 1'b1, 8'h5C);
        scan(2, 69, 8'h5C, "R8 second half write");
        scan(2, 5, 8'hA5, "R8 first half untouched");

        wr_w(1'b1, 1'b0, 1'b0, 8'hE5);
        chk("R4 start line B", int'(start_line_o[11:6]), 37);
        chk("R4 start line A", int'(start_line_o[5:0]), 0);

        wr_w(1'b0, 1'b1, 1'b0, 8'hBB);
        wr_w(1'b0, 1'b1, 1'b0, 8'h7F);
        wr_w(1'b0, 1'b1, 1'b1, 8'h0F);
        wr_w(1'b0, 1'b1, 1'b1, 8'hF0);
        scan(3, 63, 8'h0F, "R5 last column");
        scan(3, 0, 8'hF0, "R5 column wrap");

        wr_w(1'b0, 1'b1, 1'b0, 8'h3E);
        rd(1'b0, 1'b1, 1'b0, 8'h20, "R3 status off");
        chk("R3 half A off", int'(disp_on_o), 2);

        wr_w(1'b0, 1'b1, 1'b0, 8'hBC);
        wr_w(1'b0, 1'b1, 1'b0, 8'h41);
        wr_w(1'b0, 1'b1, 1'b1, 8'h01);
        wr_w(1'b0, 1'b1, 1'b0, 8'h41);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h66);
        repeat (20) @(negedge clk);
        scan(4, 1, 8'h01, "R12 no effect while E high");
        bus_e = 1'b0;
        repeat (BUSY_CYC + 16) @(negedge clk);
        scan(4, 1, 8'h66, "R12 effect after falling E");

        dir_norm = 1'b0;
        wr_w(1'b0, 1'b1, 1'b0, 8'hB9);
        wr_w(1'b0, 1'b1, 1'b0, 8'h40);
        wr_w(1'b0, 1'b1, 1'b1, 8'hE7);
        scan(1, 63, 8'hE7, "R10 mirrored column");
        wr_w(1'b0, 1'b1, 1'b0, 8'h40);
        rd(1'b0, 1'b1, 1'b1, 8'h00, "R10 mirrored dummy read");
        rd(1'b0, 1'b1, 1'b1, 8'hE7, "R10 mirrored read");
        rd(1'b1, 1'b0, 1'b0, 8'h20, "R10 swapped select status");
        rd(1'b0, 1'b1, 1'b0, 8'h00, "R10 swapped select other");
        dir_norm = 1'b1;

        wr_w(1'b0, 1'b1, 1'b0, 8'hB8);
        wr_w(1'b0, 1'b1, 1'b0, 8'h40);
        wr_w(1'b0, 1'b1, 1'b1, 8'h5A);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rd(1'b0, 1'b1, 1'b0, 8'h30, "R1 status during reset");
        wr_w(1'b0, 1'b1, 1'b1, 8'h99);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        scan(0, 0, 8'h5A, "R1 write in reset ignored");
        chk("R1 reset turns off", int'(disp_on_o), 0);
        rd(1'b0, 1'b1, 1'b0, 8'h20, "R2 status after second reset");

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule